// File: doc/BRIEF.md
# Writeback Slot Allocator

This block places finished instructions into a window of future writeback slots and sends them on to commit when their slot reaches the head of the window. The window has `W` ports per cycle and `D` cycle rows, so it holds `W*D` slots. The window works as a ring of rows and moves forward one row on every clock. The row at the head is retired on each clock edge and then cleared.

Each finish request gives an instruction id, squashed, executed and fault flags, up to `NDST` destination register tags, and a minimum row offset. The block accepts at most one request per clock. In the same cycle it searches from that offset for the first free slot. It scans the port index upward within a row, and when a row is full it moves to the next row. A request that finds no slot is reported as an error and dropped.

At retirement every occupied head slot appears on its own lane toward commit. Only an instruction that executed, is not squashed and did not fault raises the dependent-wakeup strobe and the scoreboard set strobes for its destination tags. Any other instruction is forwarded to commit unchanged.

Top module: `wb_slot_alloc`

## Requirements
- R1: While reset is low and in the first cycle after reset, `ret_valid`, `wake`, `sb_set` and `fin_err` are zero and `pend_cnt` is zero. Requests made during reset are discarded.
- R2: A request accepted in cycle t with `fin_delay` = d, into an empty window, lands in row offset d and appears on retirement lane 0 in cycle t+d+1 with its id on `ret_id`. No lane is valid in the cycles before that.
- R3: Slots in a row are taken in port index order. If every port of a row is taken, the search moves to the next row, and the instruction retires one cycle later than the requested row.
- R4: Capacity is `W*D` slots. A request with no free slot at or after its offset, including any `fin_delay` >= D, raises `fin_err` in the next cycle, is never retired and leaves `pend_cnt` unchanged.
- R5: Lane i carries port i of the head row. Lanes are filled from lane 0 upward with no gap, so a valid lane i+1 implies a valid lane i. `ret_id` lane i sits at bits [i*ID_W +: ID_W].
- R6: `wake[i]` is 1 only when the lane i instruction executed, is not squashed and did not fault. `sb_set[i*NDST+k]` is 1 only in that case and only when destination k is valid, with its tag on `sb_tag[(i*NDST+k)*TAG_W +: TAG_W]`.
- R7: A squashed, faulting or not-executed instruction still retires with `ret_valid` and its id, with `wake` and `sb_set` at zero.
- R8: `pend_cnt` equals the number of accepted requests minus the number of retired lanes, and never exceeds `W*D`.
- R9: A retired row is cleared, so each instruction is presented exactly once.
- R10: The search restarts in every cycle at the new request's own offset. A request with offset 0 may fill a free port of the row that retires at the end of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fin_valid | input | 1 | Finish request strobe |
| fin_delay | input | $clog2(D)+1 | Earliest row offset for the slot |
| fin_id | input | ID_W | Instruction id |
| fin_squashed | input | 1 | Instruction was squashed |
| fin_executed | input | 1 | Instruction executed |
| fin_fault | input | 1 | Instruction faulted |
| fin_dst_vld | input | NDST | Destination valid bits |
| fin_dst_tag | input | NDST*TAG_W | Destination tags, k at [k*TAG_W +: TAG_W] |
| fin_err | output | 1 | Previous cycle's request found no slot |
| ret_valid | output | W | Retirement lane valid |
| ret_id | output | W*ID_W | Retiring ids per lane |
| wake | output | W | Dependent-wakeup strobe per lane |
| sb_set | output | W*NDST | Scoreboard set strobes |
| sb_tag | output | W*NDST*TAG_W | Scoreboard tags |
| pend_cnt | output | $clog2(W*D+1) | Occupied slots in the window |

## Verification
A new placement and a retirement can land on the same row in the same cycle. When an offset-0 request arrives while the head row has a free port, the slot must be filled and retired at the same edge. The bench provokes this by placing one instruction at offset 1 and another at offset 0 in the next cycle, then expects both on lanes 0 and 1 together with a balanced `pend_cnt`. A second overlap, a full row forcing a spill while that row is being retired, is provoked by filling a row from three successive requests, and is judged by the split of ids across two retirement cycles.

// File: rtl/wbs_pkg.sv
// Package: shared types for the writeback slot allocator.
// Assumes nothing beyond standard SystemVerilog packed types.
package wbs_pkg;

    // Status flags carried with each finished instruction.
    typedef struct packed {
        logic squashed;
        logic executed;
        logic fault;
    } wbs_flags_t;

    // True when an instruction may wake consumers and set the scoreboard.
    function automatic logic wbs_clean(input wbs_flags_t f);
        return !f.squashed && f.executed && !f.fault;
    endfunction

endpackage

// File: rtl/wbs_finder.sv
// Module: wbs_finder
// Finds the lowest free slot in linear order (row offset * W + port)
// at or after the requested row offset. Purely combinational.
// Assumes occ_lin is ordered by offset from the head row.
module wbs_finder #(
    parameter int W     = 2,
    parameter int D     = 4,
    parameter int OFF_W = 3,
    parameter int ROW_W = 2,
    parameter int SLOT_W = 1
) (
    input  logic [W*D-1:0]    occ_lin,
    input  logic [OFF_W-1:0]  start_off,
    output logic              found,
    output logic [ROW_W-1:0]  hit_off,
    output logic [SLOT_W-1:0] hit_slot
);
    localparam int CAP = W * D;

    // Priority search: descending loop so the lowest free index wins.
    always_comb begin
        found    = 1'b0;
        hit_off  = '0;
        hit_slot = '0;
        for (int k = CAP - 1; k >= 0; k--) begin
            if (!occ_lin[k] && ((k / W) >= int'(start_off))) begin
                found    = 1'b1;
                hit_off  = ROW_W'(k / W);
                hit_slot = SLOT_W'(k % W);
            end
        end
    end
endmodule

// File: rtl/wbs_window.sv
// Module: wbs_window
// Ring of D rows with W slots each. The head row is presented (merged with
// a same-cycle write at offset 0), then cleared, and the head advances every clock.
// Assumes at most one write per cycle, to a free slot.
module wbs_window
    import wbs_pkg::*;
#(
    parameter int W      = 2,
    parameter int D      = 4,
    parameter int ID_W   = 8,
    parameter int TAG_W  = 6,
    parameter int NDST   = 2,
    parameter int ROW_W  = 2,
    parameter int SLOT_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ROW_W-1:0]        wr_off,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [ID_W-1:0]         wr_id,
    input  wbs_flags_t              wr_flags,
    input  logic [NDST-1:0]         wr_dvld,
    input  logic [NDST*TAG_W-1:0]   wr_dtag,
    output logic [W*D-1:0]          occ_lin,
    output logic [W-1:0]            head_occ,
    output logic [W*ID_W-1:0]       head_id,
    output wbs_flags_t [W-1:0]      head_flags,
    output logic [W*NDST-1:0]       head_dvld,
    output logic [W*NDST*TAG_W-1:0] head_dtag
);
    logic                  occ_q [D][W];
    logic [ID_W-1:0]       id_q  [D][W];
    wbs_flags_t            flg_q [D][W];
    logic [NDST-1:0]       dv_q  [D][W];
    logic [NDST*TAG_W-1:0] tg_q  [D][W];
    logic [ROW_W-1:0]      head_q;
    int                    wr_row;

    // Absolute row addressed by the write offset, wrapped around the ring.
    always_comb begin
        wr_row = int'(head_q) + int'(wr_off);
        if (wr_row >= D) wr_row = wr_row - D;
    end

    // Occupancy flattened in offset order for the slot search.
    always_comb begin
        for (int o = 0; o < D; o++) begin
            int r;
            r = int'(head_q) + o;
            if (r >= D) r = r - D;
            for (int s = 0; s < W; s++) occ_lin[o*W+s] = occ_q[r][s];
        end
    end

    // Head row view, with a same-cycle write to offset 0 bypassed in.
    always_comb begin
        for (int s = 0; s < W; s++) begin
            logic hit;
            hit = wr_en && (wr_off == '0) && (int'(wr_slot) == s);
            head_occ[s]                         = occ_q[head_q][s] | hit;
            head_id[s*ID_W +: ID_W]             = hit ? wr_id    : id_q[head_q][s];
            head_flags[s]                       = hit ? wr_flags : flg_q[head_q][s];
            head_dvld[s*NDST +: NDST]           = hit ? wr_dvld  : dv_q[head_q][s];
            head_dtag[s*NDST*TAG_W +: NDST*TAG_W] = hit ? wr_dtag : tg_q[head_q][s];
        end
    end

    // Occupancy and head pointer: clear the head row, mark new writes, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            for (int r = 0; r < D; r++)
                for (int s = 0; s < W; s++) occ_q[r][s] <= 1'b0;
        end else begin
            for (int r = 0; r < D; r++) begin
                for (int s = 0; s < W; s++) begin
                    if (r == int'(head_q))
                        occ_q[r][s] <= 1'b0;
                    else if (wr_en && r == wr_row && s == int'(wr_slot))
                        occ_q[r][s] <= 1'b1;
                end
            end
            head_q <= (int'(head_q) == D - 1) ? '0 : head_q + 1'b1;
        end
    end

    // Slot payload storage: written on placement, qualified by occupancy.
    always_ff @(posedge clk) begin
        for (int r = 0; r < D; r++) begin
            for (int s = 0; s < W; s++) begin
                if (wr_en && r == wr_row && s == int'(wr_slot)) begin
                    id_q[r][s]  <= wr_id;
                    flg_q[r][s] <= wr_flags;
                    dv_q[r][s]  <= wr_dvld;
                    tg_q[r][s]  <= wr_dtag;
                end
            end
        end
    end
endmodule

// File: rtl/wbs_retire.sv
// Module: wbs_retire
// Turns the head row into registered retirement lanes. Lanes stop at the
// first empty port; only clean instructions wake and set the scoreboard.
// Assumes the head view is valid in the cycle it is presented.
module wbs_retire
    import wbs_pkg::*;
#(
    parameter int W     = 2,
    parameter int ID_W  = 8,
    parameter int TAG_W = 6,
    parameter int NDST  = 2,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            head_occ,
    input  logic [W*ID_W-1:0]       head_id,
    input  wbs_flags_t [W-1:0]      head_flags,
    input  logic [W*NDST-1:0]       head_dvld,
    input  logic [W*NDST*TAG_W-1:0] head_dtag,
    output logic [CNT_W-1:0]        ret_num,
    output logic [W-1:0]            ret_valid,
    output logic [W*ID_W-1:0]       ret_id,
    output logic [W-1:0]            wake,
    output logic [W*NDST-1:0]       sb_set,
    output logic [W*NDST*TAG_W-1:0] sb_tag
);
    logic [W-1:0]      take;
    logic [W-1:0]      clean;
    logic [W*NDST-1:0] sb_d;

    // Lane selection in port order, stopping at the first empty port.
    always_comb begin
        logic run;
        run     = 1'b1;
        ret_num = '0;
        for (int s = 0; s < W; s++) begin
            take[s]  = run && head_occ[s];
            run      = take[s];
            clean[s] = take[s] && wbs_clean(head_flags[s]);
            ret_num  = ret_num + CNT_W'(take[s]);
            for (int k = 0; k < NDST; k++)
                sb_d[s*NDST+k] = clean[s] && head_dvld[s*NDST+k];
        end
    end

    // Retirement lane registers toward commit and the scoreboard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= '0;
            ret_id    <= '0;
            wake      <= '0;
            sb_set    <= '0;
            sb_tag    <= '0;
        end else begin
            ret_valid <= take;
            ret_id    <= head_id;
            wake      <= clean;
            sb_set    <= sb_d;
            sb_tag    <= head_dtag;
        end
    end
endmodule

// File: rtl/wb_slot_alloc.sv
// Module: wb_slot_alloc (top)
// Places one finished instruction per clock into a W x D writeback window
// and retires the head row every clock. Counts occupied slots and flags
// requests that find no room. Assumes one request per cycle at most.
module wb_slot_alloc
    import wbs_pkg::*;
#(
    parameter int W     = 2,
    parameter int D     = 4,
    parameter int ID_W  = 8,
    parameter int TAG_W = 6,
    parameter int NDST  = 2,
    localparam int CAP    = W * D,
    localparam int OFF_W  = $clog2(D) + 1,
    localparam int CNT_W  = $clog2(CAP + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fin_valid,
    input  logic [OFF_W-1:0]        fin_delay,
    input  logic [ID_W-1:0]         fin_id,
    input  logic                    fin_squashed,
    input  logic                    fin_executed,
    input  logic                    fin_fault,
    input  logic [NDST-1:0]         fin_dst_vld,
    input  logic [NDST*TAG_W-1:0]   fin_dst_tag,
    output logic                    fin_err,
    output logic [W-1:0]            ret_valid,
    output logic [W*ID_W-1:0]       ret_id,
    output logic [W-1:0]            wake,
    output logic [W*NDST-1:0]       sb_set,
    output logic [W*NDST*TAG_W-1:0] sb_tag,
    output logic [CNT_W-1:0]        pend_cnt
);
    localparam int ROW_W  = (D > 1) ? $clog2(D) : 1;
    localparam int SLOT_W = (W > 1) ? $clog2(W) : 1;

    logic [CAP-1:0]          occ_lin;
    logic                    found;
    logic [ROW_W-1:0]        hit_off;
    logic [SLOT_W-1:0]       hit_slot;
    logic                    accept;
    wbs_flags_t              flags;
    logic [W-1:0]            head_occ;
    logic [W*ID_W-1:0]       head_id;
    wbs_flags_t [W-1:0]      head_flags;
    logic [W*NDST-1:0]       head_dvld;
    logic [W*NDST*TAG_W-1:0] head_dtag;
    logic [CNT_W-1:0]        ret_num;

    assign flags  = '{squashed: fin_squashed, executed: fin_executed, fault: fin_fault};
    assign accept = fin_valid && found;

    wbs_finder #(
        .W(W), .D(D), .OFF_W(OFF_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_find (
        .occ_lin  (occ_lin),
        .start_off(fin_delay),
        .found    (found),
        .hit_off  (hit_off),
        .hit_slot (hit_slot)
    );

    wbs_window #(
        .W(W), .D(D), .ID_W(ID_W), .TAG_W(TAG_W), .NDST(NDST),
        .ROW_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_off    (hit_off),
        .wr_slot   (hit_slot),
        .wr_id     (fin_id),
        .wr_flags  (flags),
        .wr_dvld   (fin_dst_vld),
        .wr_dtag   (fin_dst_tag),
        .occ_lin   (occ_lin),
        .head_occ  (head_occ),
        .head_id   (head_id),
        .head_flags(head_flags),
        .head_dvld (head_dvld),
        .head_dtag (head_dtag)
    );

    wbs_retire #(
        .W(W), .ID_W(ID_W), .TAG_W(TAG_W), .NDST(NDST), .CNT_W(CNT_W)
    ) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_occ  (head_occ),
        .head_id   (head_id),
        .head_flags(head_flags),
        .head_dvld (head_dvld),
        .head_dtag (head_dtag),
        .ret_num   (ret_num),
        .ret_valid (ret_valid),
        .ret_id    (ret_id),
        .wake      (wake),
        .sb_set    (sb_set),
        .sb_tag    (sb_tag)
    );

    // Occupancy count and overflow flag: add placements, subtract retirements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt <= '0;
            fin_err  <= 1'b0;
        end else begin
            pend_cnt <= pend_cnt + CNT_W'(accept) - ret_num;
            fin_err  <= fin_valid && !found;
        end
    end
endmodule

// File: rtl/wb_slot_alloc_chk.sv
// Module: wb_slot_alloc_chk
// Property checker bound to wb_slot_alloc; observes ports only.
// Assumes synchronous active-low reset held for at least one clock.
module wb_slot_alloc_chk #(
    parameter int W     = 2,
    parameter int D     = 4,
    parameter int NDST  = 2,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fin_valid,
    input logic             fin_err,
    input logic [W-1:0]     ret_valid,
    input logic [W-1:0]     wake,
    input logic [W*NDST-1:0] sb_set,
    input logic [CNT_W-1:0] pend_cnt
);
    logic seen_q;

    // Marks that at least one clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_PEND_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (int'(pend_cnt) == int'($past(pend_cnt))
                    + (($past(fin_valid) && !fin_err) ? 1 : 0)
                    - $countones(ret_valid))); // R8

    AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_cnt) <= W * D); // R8

    AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && fin_err) |-> $past(fin_valid)); // R4

    for (genvar i = 0; i < W; i++) begin : g_lane
        AST_WAKE_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
            wake[i] |-> ret_valid[i]); // R6
        if (i > 0) begin : g_pfx
            AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
                ret_valid[i] |-> ret_valid[i-1]); // R5
        end
        for (genvar k = 0; k < NDST; k++) begin : g_dst
            AST_SB_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
                sb_set[i*NDST+k] |-> wake[i]); // R6
        end
    end
endmodule

bind wb_slot_alloc wb_slot_alloc_chk #(
    .W(W), .D(D), .NDST(NDST), .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_valid(fin_valid),
    .fin_err  (fin_err),
    .ret_valid(ret_valid),
    .wake     (wake),
    .sb_set   (sb_set),
    .pend_cnt (pend_cnt)
);

// File: tb/wb_slot_alloc_test.sv
`timescale 1ns/1ps
module wb_slot_alloc_test;
    localparam int W = 2, D = 4, ID_W = 8, TAG_W = 6, NDST = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fin_valid = 1'b0;
    logic [2:0]  fin_delay = '0;
    logic [7:0]  fin_id = '0;
    logic        fin_squashed = 1'b0, fin_executed = 1'b0, fin_fault = 1'b0;
    logic [1:0]  fin_dst_vld = '0;
    logic [11:0] fin_dst_tag = '0;
    logic        fin_err;
    logic [1:0]  ret_valid;
    logic [15:0] ret_id;
    logic [1:0]  wake;
    logic [3:0]  sb_set;
    logic [23:0] sb_tag;
    logic [3:0]  pend_cnt;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wb_slot_alloc #(.W(W), .D(D), .ID_W(ID_W), .TAG_W(TAG_W), .NDST(NDST)) uut (
        .clk(clk), .rst_n(rst_n), .fin_valid(fin_valid), .fin_delay(fin_delay),
        .fin_id(fin_id), .fin_squashed(fin_squashed), .fin_executed(fin_executed),
        .fin_fault(fin_fault), .fin_dst_vld(fin_dst_vld), .fin_dst_tag(fin_dst_tag),
        .fin_err(fin_err), .ret_valid(ret_valid), .ret_id(ret_id), .wake(wake),
        .sb_set(sb_set), .sb_tag(sb_tag), .pend_cnt(pend_cnt)
    );

    typedef struct packed {
        logic [2:0] dly;
        logic [7:0] id;
        logic       sq, ex, fl;
        logic [1:0] dv;
        logic [5:0] t1, t0;
        logic       wk;
        logic [1:0] sb;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{3'd0, 8'h11, 1'b0, 1'b1, 1'b0, 2'b11, 6'd4, 6'd3, 1'b1, 2'b11},
        '{3'd2, 8'h22, 1'b1, 1'b1, 1'b0, 2'b11, 6'd5, 6'd6, 1'b0, 2'b00},
        '{3'd1, 8'h33, 1'b0, 1'b0, 1'b0, 2'b01, 6'd1, 6'd2, 1'b0, 2'b00},
        '{3'd3, 8'h44, 1'b0, 1'b1, 1'b1, 2'b10, 6'd8, 6'd9, 1'b0, 2'b00},
        '{3'd3, 8'h55, 1'b0, 1'b1, 1'b0, 2'b10, 6'd9, 6'd7, 1'b1, 2'b10},
        '{3'd1, 8'h66, 1'b0, 1'b1, 1'b0, 2'b01, 6'd0, 6'd33, 1'b1, 2'b01}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [2:0] d, input logic [7:0] id, input logic sq,
                       input logic ex, input logic fl, input logic [1:0] dv, input logic [11:0] tg);
        fin_valid = 1'b1; fin_delay = d; fin_id = id; fin_squashed = sq;
        fin_executed = ex; fin_fault = fl; fin_dst_vld = dv; fin_dst_tag = tg;
    endtask

    task automatic drain();
        fin_valid = 1'b0;
        for (int i = 0; i < D + 2; i++) step();
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: request during reset is discarded, outputs cleared.
        put(3'd0, 8'hAA, 1'b0, 1'b1, 1'b0, 2'b11, 12'h041);
        step(); step();
        fin_valid = 1'b0;
        chk(ret_valid == 0 && wake == 0 && sb_set == 0 && !fin_err, "R1 reset outputs",
            {ret_valid, wake, sb_set}, 0);
        rst_n = 1'b1;
        step();
        chk(ret_valid == 0 && pend_cnt == 0 && !fin_err, "R1 after reset",
            {ret_valid, pend_cnt}, 0);

        // R2 R6 R7 R9: vector table, one request into an empty window each.
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            t = VECS[v];
            put(t.dly, t.id, t.sq, t.ex, t.fl, t.dv, {t.t1, t.t0});
            step();
            fin_valid = 1'b0;
            for (int c = 0; c <= int'(t.dly); c++) begin
                if (c > 0) step();
                if (c < int'(t.dly))
                    chk(ret_valid == 2'b00, "R2 early retire", ret_valid, 0);
            end
            chk(ret_valid == 2'b01 && ret_id[7:0] == t.id, "R2 retire lane0 id",
                {ret_valid, ret_id[7:0]}, {2'b01, t.id});
            chk(wake == {1'b0, t.wk}, "R6 R7 wake qualify", wake, t.wk);
            chk(sb_set == {2'b00, t.sb}, "R6 scoreboard strobes", sb_set, t.sb);
            if (t.sb[0]) chk(sb_tag[5:0] == t.t0, "R6 tag dst0", sb_tag[5:0], t.t0);
            if (t.sb[1]) chk(sb_tag[11:6] == t.t1, "R6 tag dst1", sb_tag[11:6], t.t1);
            step();
            chk(ret_valid == 2'b00, "R9 presented once", ret_valid, 0);
            drain();
            chk(pend_cnt == 0, "R8 drained", pend_cnt, 0);
        end

        // R3: fill a row over three cycles, third request spills.
        put(3'd2, 8'hA1, 1'b0, 1'b1, 1'b0, 2'b00, 12'h0); step();
        chk(pend_cnt == 1, "R8 count one", pend_cnt, 1);
        put(3'd1, 8'hB2, 1'b0, 1'b1, 1'b0, 2'b00, 12'h0); step();
        chk(pend_cnt == 2, "R8 count two", pend_cnt, 2);
        put(3'd0, 8'hC3, 1'b0, 1'b1, 1'b0, 2'b00, 12'h0); step();
        fin_valid = 1'b0;
        chk(ret_valid == 2'b11 && ret_id == 16'hB2A1, "R3 R5 full row lanes",
            {ret_valid, ret_id}, {2'b11, 16'hB2A1});
        chk(pend_cnt == 1, "R8 count after two retire", pend_cnt, 1);
        step();
        chk(ret_valid == 2'b01 && ret_id[7:0] == 8'hC3, "R3 spill next row",
            {ret_valid, ret_id[7:0]}, {2'b01, 8'hC3});
        chk(pend_cnt == 0, "R8 count empty", pend_cnt, 0);
        drain();

        // R10: offset-0 request joins the head row retiring this cycle.
        put(3'd1, 8'h5A, 1'b0, 1'b1, 1'b0, 2'b01, 12'h00B); step();
        put(3'd0, 8'h6B, 1'b1, 1'b1, 1'b0, 2'b01, 12'h00C); step();
        fin_valid = 1'b0;
        chk(ret_valid == 2'b11 && ret_id == 16'h6B5A, "R10 same-cycle head fill",
            {ret_valid, ret_id}, {2'b11, 16'h6B5A});
        chk(wake == 2'b01 && sb_set == 4'b0001, "R7 squashed lane1 no wake",
            {wake, sb_set}, {2'b01, 4'b0001});
        chk(pend_cnt == 0, "R10 R8 balance", pend_cnt, 0);
        drain();

        // R4: offsets beyond the window are rejected.
        put(3'd4, 8'hE0, 1'b0, 1'b1, 1'b0, 2'b01, 12'h001); step();
        put(3'd7, 8'hE1, 1'b0, 1'b1, 1'b0, 2'b01, 12'h001); 
        chk(fin_err == 1'b1 && pend_cnt == 0, "R4 error offset D", {fin_err, pend_cnt}, 5'h10);
        step();
        fin_valid = 1'b0;
        chk(fin_err == 1'b1 && pend_cnt == 0, "R4 error offset 7", {fin_err, pend_cnt}, 5'h10);
        for (int i = 0; i < D + 2; i++) begin
            step();
            chk(ret_valid == 2'b00, "R4 dropped never retires", ret_valid, 0);
        end
        chk(fin_err == 1'b0, "R4 error clears", fin_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule